// File: doc/BRIEF.md
# Jet Region-of-Interest Threshold Reporter

This block takes, for each event, the jet transverse-energy sums of eight subregions and decides which of them hold a jet worth reporting. Each subregion supplies two sums, one per jet window size: a 10-bit sum for the first window and a 9-bit sum for the second. It also supplies a 2-bit fine-position code. A bank of sixteen programmable entries sets the cut. Each entry has a 10-bit threshold and a 2-bit window selector. The selector either disables the entry or says which of the two sums the threshold applies to.

A subregion qualifies when the sum picked by at least one enabled entry is strictly above that entry's threshold. The result goes out on one packed real-time word with a fixed layout. The word holds one presence bit per subregion and up to four per-RoI records. Each record carries a fine-position code and both energy sums. Threshold entries are loaded through a plain address/data write port. The output is registered and changes only in response to an event strobe. The latency is fixed and does not depend on how many subregions qualify.

Top module: `jet_roi_reporter`

## Requirements
- R1: After reset, `out_valid` is 0 and `roi_word` is all zero. Every threshold entry holds 0x3FF, which is selector 0 (disabled) with threshold 0x3FF, so an event with maximal sums reports nothing.
- R2: A write with `cfg_we`=1 and `cfg_addr` = 200+i (i = 0..15) loads entry i: selector from `cfg_wdata[11:10]`, threshold from `cfg_wdata[9:0]`. Writes to any other address change no entry.
- R3: Selector codes: 0 disables the entry. 1 compares the first-window sum. 2 compares the second-window sum, zero-extended to 10 bits. 3 qualifies if either sum exceeds the threshold. The comparison is strictly greater-than.
- R4: Presence bit s (`roi_word[s]`, s = 0..7) is 1 exactly when subregion s qualifies. This holds even when more than four subregions qualify.
- R5: Record slot k (k = 0..3) describes the k-th lowest-indexed qualifying subregion. Its fine position is at `roi_word[8+2k +: 2]`, its first-window sum at `roi_word[16+10k +: 10]`, and its second-window sum at `roi_word[56+9k +: 9]`.
- R6: Record slots with no qualifying subregion to describe are all zero.
- R7: An event strobe sampled at clock edge n produces a one-cycle `out_valid` pulse and the new `roi_word` after edge n+2. This latency is the same for every input pattern.
- R8: Between events, `roi_word` holds its last value and `out_valid` is 0.
- R9: Qualification is the OR over all sixteen entries. Entries with different selectors and thresholds combine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Threshold entry write enable |
| cfg_addr | input | 8 | Write address; entries at 200..215 |
| cfg_wdata | input | 12 | Write data: [11:10] selector, [9:0] threshold |
| ev_strobe | input | 1 | Event strobe; inputs below are sampled with it |
| ev_ea | input | 80 | First-window sums, subregion s at [10s +: 10] |
| ev_eb | input | 72 | Second-window sums, subregion s at [9s +: 9] |
| ev_fpos | input | 16 | Fine-position codes, subregion s at [2s +: 2] |
| out_valid | output | 1 | One-cycle pulse when `roi_word` is updated |
| roi_word | output | 92 | Packed presence bits and four RoI records |

## Verification
The assertions check, on every cycle, properties that need no knowledge of the thresholds or sums. They cover the fixed two-edge distance from strobe to output pulse, the holding of the word between pulses, the zero state after reset, and the all-zero word when no presence bit is set. What only the bench scenarios can show are the decisions that depend on the data. Those are the strict threshold boundary for each selector code, the OR across several entries, the address decode of the write port, and the lowest-index choice of four records when more subregions qualify. The bench covers them by sweeping all 256 qualifying subsets under each selector mode.

// File: rtl/jrr_pkg.sv
package jrr_pkg;

    localparam int N_SUB    = 8;
    localparam int N_THR    = 16;
    localparam int N_SLOT   = 4;
    localparam int EA_W     = 10;
    localparam int EB_W     = 9;
    localparam int THR_W    = 10;
    localparam int FP_W     = 2;
    localparam int ADDR_W   = 8;
    localparam int THR_BASE = 200;

    localparam int WORD_W   = N_SUB + N_SLOT * (FP_W + EA_W + EB_W);
    localparam int FP_LO    = N_SUB;
    localparam int EA_LO    = FP_LO + N_SLOT * FP_W;
    localparam int EB_LO    = EA_LO + N_SLOT * EA_W;

    typedef enum logic [1:0] {
        SEL_OFF    = 2'd0,
        SEL_WIN_A  = 2'd1,
        SEL_WIN_B  = 2'd2,
        SEL_EITHER = 2'd3
    } win_sel_e;

    typedef struct packed {
        win_sel_e          sel;
        logic [THR_W-1:0]  thr;
    } thr_entry_t;

    localparam int ENTRY_W = $bits(thr_entry_t);
    localparam thr_entry_t ENTRY_RST = '{sel: SEL_OFF, thr: {THR_W{1'b1}}};

    typedef struct packed {
        logic [EA_W-1:0] ea;
        logic [EB_W-1:0] eb;
        logic [FP_W-1:0] fp;
    } sub_in_t;

    function automatic logic entry_fires(input thr_entry_t e,
                                         input logic [EA_W-1:0] ea,
                                         input logic [EB_W-1:0] eb);
        logic a_over;
        logic b_over;
        a_over = ea > e.thr;
        b_over = THR_W'(eb) > e.thr;
        case (e.sel)
            SEL_WIN_A:  return a_over;
            SEL_WIN_B:  return b_over;
            SEL_EITHER: return a_over | b_over;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/jrr_thr_bank.sv
module jrr_thr_bank
    import jrr_pkg::*;
#(
    parameter int NUM   = N_THR,
    parameter int AW    = ADDR_W,
    parameter int BASE  = THR_BASE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output thr_entry_t         bank [NUM]
);

    for (genvar i = 0; i < NUM; i++) begin : g_entry
        logic sel_hit;
        assign sel_hit = wr_en && (wr_addr == AW'(BASE + i));

        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= ENTRY_RST;
            end else if (sel_hit) begin
                bank[i] <= thr_entry_t'(wr_data);
            end
        end
    end

endmodule

// File: rtl/jrr_qualify.sv
module jrr_qualify
    import jrr_pkg::*;
#(
    parameter int NS = N_SUB,
    parameter int NT = N_THR
) (
    input  thr_entry_t      bank [NT],
    input  sub_in_t         subs [NS],
    output logic [NS-1:0]   hit
);

    for (genvar s = 0; s < NS; s++) begin : g_sub
        always_comb begin
            hit[s] = 1'b0;
            for (int t = 0; t < NT; t++) begin
                if (entry_fires(bank[t], subs[s].ea, subs[s].eb)) begin
                    hit[s] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/jrr_pack.sv
module jrr_pack
    import jrr_pkg::*;
#(
    parameter int NS = N_SUB,
    parameter int NK = N_SLOT
) (
    input  logic [NS-1:0]     hit,
    input  sub_in_t           subs [NS],
    output logic [WORD_W-1:0] word
);

    always_comb begin
        int slot;
        word          = '0;
        word[NS-1:0]  = hit;
        slot          = 0;
        for (int s = 0; s < NS; s++) begin
            if (hit[s] && (slot < NK)) begin
                word[FP_LO + slot * FP_W +: FP_W] = subs[s].fp;
                word[EA_LO + slot * EA_W +: EA_W] = subs[s].ea;
                word[EB_LO + slot * EB_W +: EB_W] = subs[s].eb;
                slot = slot + 1;
            end
        end
    end

endmodule

// File: rtl/jet_roi_reporter.sv
module jet_roi_reporter
    import jrr_pkg::*;
#(
    parameter int NS = N_SUB,
    parameter int NT = N_THR,
    parameter int NK = N_SLOT
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [ENTRY_W-1:0]   cfg_wdata,
    input  logic                 ev_strobe,
    input  logic [NS*EA_W-1:0]   ev_ea,
    input  logic [NS*EB_W-1:0]   ev_eb,
    input  logic [NS*FP_W-1:0]   ev_fpos,
    output logic                 out_valid,
    output logic [WORD_W-1:0]    roi_word
);

    thr_entry_t        bank [NT];
    sub_in_t           in_sub [NS];
    sub_in_t           s0_sub [NS];
    sub_in_t           s1_sub [NS];
    logic              s0_valid;
    logic              s1_valid;
    logic [NS-1:0]     qual_hit;
    logic [NS-1:0]     s1_hit;
    logic [WORD_W-1:0] packed_word;

    jrr_thr_bank #(.NUM(NT), .AW(ADDR_W), .BASE(THR_BASE)) bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_wdata),
        .bank    (bank)
    );

    for (genvar s = 0; s < NS; s++) begin : g_unpack
        assign in_sub[s].ea = ev_ea[s*EA_W +: EA_W];
        assign in_sub[s].eb = ev_eb[s*EB_W +: EB_W];
        assign in_sub[s].fp = ev_fpos[s*FP_W +: FP_W];
    end

    // Stage 0: capture event inputs on strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            s0_valid <= 1'b0;
            for (int s = 0; s < NS; s++) s0_sub[s] <= '0;
        end else begin
            s0_valid <= ev_strobe;
            if (ev_strobe) begin
                for (int s = 0; s < NS; s++) s0_sub[s] <= in_sub[s];
            end
        end
    end

    jrr_qualify #(.NS(NS), .NT(NT)) qual_i (
        .bank (bank),
        .subs (s0_sub),
        .hit  (qual_hit)
    );

    // Stage 1: register qualification mask
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hit   <= '0;
            for (int s = 0; s < NS; s++) s1_sub[s] <= '0;
        end else begin
            s1_valid <= s0_valid;
            if (s0_valid) begin
                s1_hit <= qual_hit;
                for (int s = 0; s < NS; s++) s1_sub[s] <= s0_sub[s];
            end
        end
    end

    jrr_pack #(.NS(NS), .NK(NK)) pack_i (
        .hit  (s1_hit),
        .subs (s1_sub),
        .word (packed_word)
    );

    // Stage 2: output word
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            roi_word  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                roi_word <= packed_word;
            end
        end
    end

endmodule

// File: rtl/jrr_checker.sv
module jrr_checker
    import jrr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_strobe,
    input logic              out_valid,
    input logic [WORD_W-1:0] roi_word
);

    // R1: output registers are clear right after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (roi_word == '0 && !out_valid));

    // R7: every output pulse stems from a strobe two edges earlier
    p_fixed_latency_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(ev_strobe, 3));

    // R8: word is held while no pulse
    p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(roi_word));

    // R6: no presence means every record slot is empty
    p_empty_slots_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && roi_word[N_SUB-1:0] == '0) |-> (roi_word == '0));

endmodule

bind jet_roi_reporter jrr_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .ev_strobe (ev_strobe),
    .out_valid (out_valid),
    .roi_word  (roi_word)
);

// File: tb/jet_roi_reporter_tb_top.sv
module jet_roi_reporter_tb_top;
    import jrr_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  cfg_we = 1'b0;
    logic [ADDR_W-1:0]     cfg_addr = '0;
    logic [ENTRY_W-1:0]    cfg_wdata = '0;
    logic                  ev_strobe = 1'b0;
    logic [N_SUB*EA_W-1:0] ev_ea = '0;
    logic [N_SUB*EB_W-1:0] ev_eb = '0;
    logic [N_SUB*FP_W-1:0] ev_fpos = '0;
    logic                  out_valid;
    logic [WORD_W-1:0]     roi_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [1:0]      m_sel [N_THR];
    logic [THR_W-1:0] m_thr [N_THR];
    logic [EA_W-1:0] t_ea [N_SUB];
    logic [EB_W-1:0] t_eb [N_SUB];
    logic [FP_W-1:0] t_fp [N_SUB];

    always #10 clk = ~clk;

    jet_roi_reporter dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ev_strobe (ev_strobe),
        .ev_ea     (ev_ea),
        .ev_eb     (ev_eb),
        .ev_fpos   (ev_fpos),
        .out_valid (out_valid),
        .roi_word  (roi_word)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] model();
        logic [WORD_W-1:0] w;
        int k;
        bit q;
        w = '0;
        k = 0;
        for (int s = 0; s < N_SUB; s++) begin
            q = 1'b0;
            for (int t = 0; t < N_THR; t++) begin
                case (m_sel[t])
                    2'd1: if (int'(t_ea[s]) > int'(m_thr[t])) q = 1'b1;
                    2'd2: if (int'(t_eb[s]) > int'(m_thr[t])) q = 1'b1;
                    2'd3: if (int'(t_ea[s]) > int'(m_thr[t]) ||
                              int'(t_eb[s]) > int'(m_thr[t])) q = 1'b1;
                    default: ;
                endcase
            end
            if (q) begin
                w[s] = 1'b1;
                if (k < N_SLOT) begin
                    w[8 + 2*k +: 2]   = t_fp[s];
                    w[16 + 10*k +: 10] = t_ea[s];
                    w[56 + 9*k +: 9]   = t_eb[s];
                    k++;
                end
            end
        end
        return w;
    endfunction

    task automatic cfg_write(input int addr, input logic [1:0] sel, input logic [9:0] thr);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = ADDR_W'(addr);
        cfg_wdata = {sel, thr};
        @(negedge clk);
        cfg_we    = 1'b0;
        if (addr >= 200 && addr < 216) begin
            m_sel[addr-200] = sel;
            m_thr[addr-200] = thr;
        end
    endtask

    task automatic clear_bank();
        for (int i = 0; i < N_THR; i++) cfg_write(200 + i, 2'd0, 10'h3FF);
    endtask

    task automatic run_event(input string req);
        logic [WORD_W-1:0] exp;
        @(negedge clk);
        for (int s = 0; s < N_SUB; s++) begin
            ev_ea[s*EA_W +: EA_W]   = t_ea[s];
            ev_eb[s*EB_W +: EB_W]   = t_eb[s];
            ev_fpos[s*FP_W +: FP_W] = t_fp[s];
        end
        ev_strobe = 1'b1;
        exp = model();
        @(negedge clk);
        ev_strobe = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 early pulse", WORD_W'(out_valid), '0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 pulse at edge n+2", WORD_W'(out_valid), WORD_W'(1));
        chk(roi_word == exp, req, roi_word, exp);
        @(negedge clk);
        chk(!out_valid && roi_word == exp, "R8 hold", roi_word, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N_THR; i++) begin
            m_sel[i] = 2'd0;
            m_thr[i] = 10'h3FF;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(roi_word == '0 && !out_valid, "R1 reset state", roi_word, '0);
        for (int s = 0; s < N_SUB; s++) begin
            t_ea[s] = '1; t_eb[s] = '1; t_fp[s] = 2'(s);
        end
        run_event("R1 reset entries report nothing");

        // R3/R4/R5/R6: window A, strict boundary, all subsets
        cfg_write(200, 2'd1, 10'd100);
        for (int m = 0; m < 256; m++) begin
            for (int s = 0; s < N_SUB; s++) begin
                t_ea[s] = ((m >> s) & 1) != 0 ? 10'd101 : 10'd100;
                t_eb[s] = 9'((s * 37 + m) % 512);
                t_fp[s] = 2'((s + m) % 4);
            end
            run_event("R3 R4 R5 R6 window A sweep");
        end

        // R3: window B, first-window sum ignored
        cfg_write(200, 2'd2, 10'd50);
        for (int m = 0; m < 256; m++) begin
            for (int s = 0; s < N_SUB; s++) begin
                t_ea[s] = 10'h3FF;
                t_eb[s] = ((m >> s) & 1) != 0 ? 9'd51 : 9'd50;
                t_fp[s] = 2'((3 * s + m) % 4);
            end
            run_event("R3 R5 window B sweep");
        end

        // R3: either window
        cfg_write(200, 2'd3, 10'd200);
        for (int m = 0; m < 256; m++) begin
            for (int s = 0; s < N_SUB; s++) begin
                t_ea[s] = (((m >> s) & 1) != 0 && (s % 2) == 0) ? 10'd201 : 10'd200;
                t_eb[s] = (((m >> s) & 1) != 0 && (s % 2) == 1) ? 9'd201 : 9'd200;
                t_fp[s] = 2'(m % 4);
            end
            run_event("R3 either window sweep");
        end

        // R9: OR of several entries with different selectors
        clear_bank();
        cfg_write(203, 2'd1, 10'd500);
        cfg_write(215, 2'd2, 10'd20);
        for (int m = 0; m < 256; m++) begin
            for (int s = 0; s < N_SUB; s++) begin
                t_ea[s] = ((m >> s) & 1) != 0 ? 10'd501 : 10'(17 * s);
                t_eb[s] = (((m * 3) >> s) & 1) != 0 ? 9'd21 : 9'd20;
                t_fp[s] = 2'(s % 4);
            end
            run_event("R9 multi-entry OR sweep");
        end

        // R2: writes outside 200..215 ignored, 215 accepted
        clear_bank();
        cfg_write(199, 2'd1, 10'd0);
        cfg_write(216, 2'd1, 10'd0);
        cfg_write(72, 2'd3, 10'd0);
        for (int s = 0; s < N_SUB; s++) begin
            t_ea[s] = 10'd5; t_eb[s] = 9'd5; t_fp[s] = 2'd1;
        end
        run_event("R2 out-of-range writes ignored");
        chk(roi_word[7:0] == 8'h00, "R2 no presence", roi_word, '0);
        cfg_write(215, 2'd1, 10'd0);
        run_event("R2 last entry write");
        chk(roi_word[7:0] == 8'hFF, "R2 R4 all present", roi_word, WORD_W'(8'hFF));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule